// File: doc/BRIEF.md
# Mode-Switchable Interrupt Level Router

This block gathers five peripheral interrupt request lines (controller A, controller B, Ethernet, serial and non-maskable) and condenses them into the 3-bit interrupt priority level presented to a 68k-style processor. Each request line maps to one priority level. The mapping comes from one of two routing tables. A one-bit table selector sets which table is in use. The selector is latched from bit 6 of a port write. With the native table (selector 0), Ethernet is served at a CPU level. With the compat table (selector 1), Ethernet is taken out of the CPU levels and its request is mirrored onto a separate slot-interrupt output.

Every routed request line drives one bit of a pending register, at position level minus one. The bit is set on a rising request and cleared on a falling one. The CPU level output is the highest pending level. A non-maskable trigger pulse starts a stretcher that holds the non-maskable request for a programmable number of millisecond ticks, 100 by default. The stretcher is a two-state machine: HOLD_IDLE moves to HOLD_ACTIVE on a trigger. HOLD_ACTIVE restarts its count on a new trigger and returns to HOLD_IDLE when the last tick of the hold arrives. The table selector is also a two-state machine: TBL_NATIVE moves to TBL_COMPAT on a port write with bit 6 set, and TBL_COMPAT moves back on a port write with bit 6 clear. Any other write leaves the selector where it is.

Top module: `irq_level_router`

## Requirements
- R1: While reset is low and afterwards until a stimulus arrives, cpu_ipl is 0 and slot_irq is 0. Reset selects the native table and cancels any non-maskable hold.
- R2: Native table (selector 0): controller A (irq_req[0]) goes to level 6, controller B (irq_req[1]) to level 2, Ethernet (irq_req[2]) to level 3, serial (irq_req[3]) to level 4, and non-maskable (irq_req[4]) to level 7.
- R3: Compat table (selector 1): controller A goes to level 1, controller B to level 2, serial to level 4, and non-maskable to level 7.
- R4: Under the compat table, Ethernet sets no pending level and slot_irq equals irq_req[2] combinationally. Under the native table, slot_irq is 0.
- R5: A routed request rising sets pending level L, and the same request falling clears it. cpu_ipl reflects the change one clock edge after the request is sampled.
- R6: cpu_ipl equals the highest pending level (1 to 7), or 0 when nothing is pending.
- R7: A one-cycle nmi_trig pulse raises level 7 two clock edges later. Level 7 is held until HOLD_TICKS ms_tick pulses have been counted after the last trigger. A trigger during a hold restarts the count.
- R8: The table selector changes only on a port_wr cycle in which port_data[6] differs from the current selector, and takes effect from the next clock edge. A write that leaves bit 6 unchanged has no effect.
- R9: Switching tables leaves the levels already pending untouched. Only later request transitions use the new table, so a request that drops after a switch clears the level of the new table.
- R10: Asserting reset during a non-maskable hold ends the hold. Level 7 does not return after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 5 | Request lines: 0 controller A, 1 controller B, 2 Ethernet, 3 serial, 4 non-maskable |
| nmi_trig | input | 1 | One-cycle pulse that starts or restarts the non-maskable hold |
| ms_tick | input | 1 | One-cycle enable per millisecond, used to count the hold |
| port_wr | input | 1 | Port write strobe |
| port_data | input | PORT_W | Port write data; bit MODE_BIT (6) selects the table |
| cpu_ipl | output | 3 | Interrupt priority level to the processor |
| slot_irq | output | 1 | Ethernet request mirrored under the compat table |

## Verification
A request change sampled at clock edge k shows up on cpu_ipl after edge k. slot_irq follows irq_req[2] in the same cycle, once a table switch written at edge k has taken effect. A trigger pulse sampled at edge k gives level 7 after edge k+1, and the release lands one edge after the final counted tick. The bench drives its inputs two nanoseconds after the falling edge and samples them at the rising edge. At every falling edge it compares both outputs with a behavioural model that has absorbed the same rising edges. The directed checks are placed at the exact cycle counts listed above, and the hold-release check brackets the release with margins on both sides.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int NSRC   = 5;
    localparam int LVL_W  = 3;
    localparam int PEND_W = (1 << LVL_W) - 1;

    localparam int SRC_CTLA = 0;
    localparam int SRC_CTLB = 1;
    localparam int SRC_ETH  = 2;
    localparam int SRC_SER  = 3;
    localparam int SRC_NMI  = 4;

    typedef enum logic {
        TBL_NATIVE = 1'b0,
        TBL_COMPAT = 1'b1
    } table_e;

    typedef enum logic {
        HOLD_IDLE   = 1'b0,
        HOLD_ACTIVE = 1'b1
    } hold_state_e;

    // Level for a source under a table; 0 means the source is not routed.
    function automatic logic [LVL_W-1:0] route_level(input int src, input table_e tbl);
        logic [LVL_W-1:0] lvl;
        lvl = '0;
        unique case (src)
            SRC_CTLA: lvl = (tbl == TBL_COMPAT) ? 3'd1 : 3'd6;
            SRC_CTLB: lvl = 3'd2;
            SRC_ETH:  lvl = (tbl == TBL_COMPAT) ? 3'd0 : 3'd3;
            SRC_SER:  lvl = 3'd4;
            SRC_NMI:  lvl = 3'd7;
            default:  lvl = '0;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/irq_table_latch.sv
module irq_table_latch
    import irq_router_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  logic   sel_bit,
    output table_e tbl
);

    table_e tbl_q, tbl_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= TBL_NATIVE;
        else        tbl_q <= tbl_d;
    end

    always_comb begin
        tbl_d = tbl_q;
        unique case (tbl_q)
            TBL_NATIVE: if (wr_en && sel_bit)  tbl_d = TBL_COMPAT;
            TBL_COMPAT: if (wr_en && !sel_bit) tbl_d = TBL_NATIVE;
            default:    tbl_d = TBL_NATIVE;
        endcase
    end

    assign tbl = tbl_q;

endmodule

// File: rtl/irq_nmi_stretch.sv
module irq_nmi_stretch
    import irq_router_pkg::*;
#(
    parameter int HOLD_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic tick,
    output logic hold
);

    localparam int CNT_W = $clog2(HOLD_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

    hold_state_e st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= HOLD_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            HOLD_IDLE: begin
                if (trig) begin
                    st_d  = HOLD_ACTIVE;
                    cnt_d = '0;
                end
            end
            HOLD_ACTIVE: begin
                if (trig) begin
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q == LAST) begin
                        st_d  = HOLD_IDLE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                st_d  = HOLD_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    assign hold = (st_q == HOLD_ACTIVE);

endmodule

// File: rtl/irq_pending.sv
module irq_pending
    import irq_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src,
    input  table_e            tbl,
    output logic [PEND_W-1:0] pend
);

    logic [NSRC-1:0]   src_q;
    logic [PEND_W-1:0] pend_q;
    logic [LVL_W-1:0]  lvl [NSRC];

    for (genvar g = 0; g < NSRC; g++) begin : g_route
        assign lvl[g] = route_level(g, tbl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            pend_q <= '0;
        end else begin
            src_q <= src;
            for (int i = 0; i < NSRC; i++) begin
                if ((src[i] != src_q[i]) && (lvl[i] != '0)) begin
                    pend_q[lvl[i] - 1'b1] <= src[i];
                end
            end
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_router_pkg::*;
(
    input  logic [PEND_W-1:0] pend,
    output logic [LVL_W-1:0]  level
);

    always_comb begin
        level = '0;
        for (int i = 0; i < PEND_W; i++) begin
            if (pend[i]) level = LVL_W'(i + 1);
        end
    end

endmodule

// File: rtl/irq_level_router.sv
module irq_level_router
    import irq_router_pkg::*;
#(
    parameter int HOLD_TICKS = 100,
    parameter int PORT_W     = 8,
    parameter int MODE_BIT   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_req,
    input  logic              nmi_trig,
    input  logic              ms_tick,
    input  logic              port_wr,
    input  logic [PORT_W-1:0] port_data,
    output logic [LVL_W-1:0]  cpu_ipl,
    output logic              slot_irq
);

    table_e            tbl;
    logic              tbl_compat;
    logic              nmi_hold;
    logic [NSRC-1:0]   src_eff;
    logic [PEND_W-1:0] pend_q;
    logic              port_unused;

    assign port_unused = ^port_data;

    irq_table_latch u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (port_wr),
        .sel_bit (port_data[MODE_BIT]),
        .tbl     (tbl)
    );

    irq_nmi_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_nmi (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (nmi_trig),
        .tick  (ms_tick),
        .hold  (nmi_hold)
    );

    always_comb begin
        src_eff          = irq_req;
        src_eff[SRC_NMI] = irq_req[SRC_NMI] | nmi_hold;
    end

    irq_pending u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src_eff),
        .tbl   (tbl),
        .pend  (pend_q)
    );

    irq_prio_enc u_enc (
        .pend  (pend_q),
        .level (cpu_ipl)
    );

    assign tbl_compat = (tbl == TBL_COMPAT);
    assign slot_irq   = tbl_compat & irq_req[SRC_ETH];

endmodule

// File: rtl/irq_level_router_chk.sv
module irq_level_router_chk
    import irq_router_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              port_wr,
    input logic              tbl_compat,
    input logic [PEND_W-1:0] pend,
    input logic              nmi_hold,
    input logic [LVL_W-1:0]  cpu_ipl,
    input logic              slot_irq
);

    p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (cpu_ipl == '0));

    p_top_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pend[PEND_W-1] |-> (cpu_ipl == 3'd7));

    p_slot_native_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tbl_compat |-> !slot_irq);

    p_eth_unrouted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_compat |=> $stable(pend[2]));

    p_hold_reaches_cpu_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_hold |=> pend[6]);

    p_table_needs_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !port_wr |=> $stable(tbl_compat));

endmodule

bind irq_level_router irq_level_router_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_wr    (port_wr),
    .tbl_compat (tbl_compat),
    .pend       (pend_q),
    .nmi_hold   (nmi_hold),
    .cpu_ipl    (cpu_ipl),
    .slot_irq   (slot_irq)
);

// File: tb/tb_irq_level_router.sv
module tb_irq_level_router;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] req;
    logic       trig, tick, tick_en, wr;
    logic [7:0] pdata;
    wire  [2:0] ipl;
    wire        slot;

    always #10 clk = ~clk;

    irq_level_router dut (
        .clk(clk), .rst_n(rst_n), .irq_req(req), .nmi_trig(trig),
        .ms_tick(tick), .port_wr(wr), .port_data(pdata),
        .cpu_ipl(ipl), .slot_irq(slot)
    );

    integer n_chk = 0, n_fail = 0, cyc = 0;
    bit     done = 1'b0;
    string  phase = "R1";

    // behavioural reference state
    bit       m_mode;
    bit [6:0] m_pend;
    bit [4:0] m_prev;
    bit       m_hold;
    int       m_cnt;

    function automatic int lvl_of(int s, bit md);
        case (s)
            0: return md ? 1 : 6;
            1: return 2;
            2: return md ? 0 : 3;
            3: return 4;
            default: return 7;
        endcase
    endfunction

    function automatic int exp_ipl();
        int r = 0;
        for (int i = 0; i < 7; i++) if (m_pend[i]) r = i + 1;
        return r;
    endfunction

    task automatic chk(string r, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", r, act, exp, cyc);
        end
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    always @(posedge clk) begin : model
        bit [4:0] s;
        int l;
        if (!rst_n) begin
            m_mode = 0; m_pend = '0; m_prev = '0; m_hold = 0; m_cnt = 0;
        end else begin
            s = {req[4] | m_hold, req[3:0]};
            for (int i = 0; i < 5; i++) begin
                if (s[i] != m_prev[i]) begin
                    l = lvl_of(i, m_mode);
                    if (l > 0) m_pend[l-1] = s[i];
                end
            end
            m_prev = s;
            if (trig) begin
                m_hold = 1; m_cnt = 0;
            end else if (m_hold && tick) begin
                if (m_cnt == 99) begin m_hold = 0; m_cnt = 0; end
                else m_cnt++;
            end
            if (wr) m_mode = pdata[6];
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({phase, " ipl model"}, int'(ipl), exp_ipl());
            chk({phase, " slot model"}, int'(slot), int'(m_mode & req[2]));
        end
    end

    always @(negedge clk) begin
        #2 tick = tick_en ? ~tick : 1'b0;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog: actual %0d cycles expected completion", cyc);
            finish_up();
        end
    end

    initial begin
        rst_n = 0; req = '0; trig = 0; tick = 0; tick_en = 0; wr = 0; pdata = '0;
        step(3);
        chk("R1 reset ipl", int'(ipl), 0);
        chk("R1 reset slot", int'(slot), 0);
        rst_n = 1;
        step(1);
        chk("R1 idle ipl", int'(ipl), 0);

        // native table
        phase = "R2";
        req[0] = 1; step(1); chk("R2 ctlA level", int'(ipl), 6);
        req[3] = 1; step(1); chk("R2 serial under ctlA", int'(ipl), 6);
        phase = "R6";
        req[0] = 0; step(1); chk("R6 serial highest", int'(ipl), 4);
        phase = "R2";
        req[2] = 1; step(1); chk("R2 eth below serial", int'(ipl), 4);
        chk("R4 native slot", int'(slot), 0);
        req[3] = 0; step(1); chk("R2 eth level", int'(ipl), 3);
        req[1] = 1; req[2] = 0; step(1); chk("R2 ctlB level", int'(ipl), 2);
        phase = "R5";
        req[1] = 0; step(1); chk("R5 cleared", int'(ipl), 0);

        // switch to compat table
        phase = "R8";
        wr = 1; pdata = 8'h40; step(1); wr = 0;
        phase = "R4";
        req[2] = 1; step(1);
        chk("R4 slot follows eth", int'(slot), 1);
        chk("R4 eth not pending", int'(ipl), 0);
        phase = "R3";
        req[0] = 1; step(1); chk("R3 ctlA level", int'(ipl), 1);
        req[3] = 1; step(1); chk("R3 serial level", int'(ipl), 4);
        req[3] = 0; req[4] = 1; step(1); chk("R3 nmi level", int'(ipl), 7);
        req[4] = 0; step(1); chk("R3 back to ctlA", int'(ipl), 1);
        req[2] = 0; step(1); chk("R4 slot drops", int'(slot), 0);

        // write without bit change
        phase = "R8";
        wr = 1; pdata = 8'hFF; step(1); wr = 0;
        req[2] = 1; step(1); chk("R8 unchanged table", int'(slot), 1);
        req[2] = 0; step(1);

        // back to native; pending survives
        phase = "R9";
        wr = 1; pdata = 8'hBF; step(1); wr = 0;
        chk("R9 level kept on switch", int'(ipl), 1);
        req[0] = 0; step(1); chk("R9 drop uses new table", int'(ipl), 1);
        req[2] = 1; step(1);
        chk("R8 native slot", int'(slot), 0);
        chk("R9 eth native over kept", int'(ipl), 3);
        req[2] = 0; step(1); chk("R9 kept level again", int'(ipl), 1);
        wr = 1; pdata = 8'h40; step(1); wr = 0;
        req[0] = 1; step(1); req[0] = 0; step(1);
        chk("R9 cleared under compat", int'(ipl), 0);
        wr = 1; pdata = 8'h00; step(1); wr = 0;

        // nmi stretcher
        phase = "R7";
        tick_en = 1;
        trig = 1; step(1); trig = 0;
        chk("R7 not yet", int'(ipl), 0);
        step(1); chk("R7 raised", int'(ipl), 7);
        step(100); chk("R7 mid hold", int'(ipl), 7);
        trig = 1; step(1); trig = 0;
        step(190); chk("R7 restarted hold", int'(ipl), 7);
        step(20); chk("R7 released", int'(ipl), 0);

        // reset during hold
        phase = "R10";
        wr = 1; pdata = 8'h40; step(1); wr = 0;
        trig = 1; step(1); trig = 0;
        step(5); chk("R10 hold before reset", int'(ipl), 7);
        rst_n = 0; step(2);
        chk("R10 reset ipl", int'(ipl), 0);
        rst_n = 1; step(5);
        chk("R10 hold cancelled", int'(ipl), 0);
        phase = "R1";
        req[2] = 1; step(1);
        chk("R1 native after reset slot", int'(slot), 0);
        chk("R1 native after reset ipl", int'(ipl), 3);
        req[2] = 0; step(2);

        finish_up();
    end

endmodule